// File: doc/BRIEF.md
# Temperature Threshold Alert Controller

This block turns a stream of temperature conversion results into a thermostat alert. Each time a conversion completes, a signed 12-bit sample arrives with a one-cycle valid strobe. The block compares the sample against a high limit and a low limit. A two-bit fault-queue field sets how many consecutive qualifying conversions are needed before the alert changes state.

There are two thermostat modes. In comparator mode the alert follows the temperature: it rises after enough samples at or above the high limit and falls after enough samples below the low limit. In interrupt mode the alert latches. It stays asserted until a register-read pulse, an alert-response pulse or a shutdown command clears it. Each clear moves the watch to the opposite limit, so interrupts alternate between an over-temperature event and a return below the low limit.

A polarity input inverts only the physical pin. The active-high internal alert state is also brought out on a port.

Top module: `temp_alert_ctrl`

## Requirements
- R1: After reset, alert_flag_o is 0 and alert_o equals pol_i.
- R2: Samples and limits are compared as 12-bit two's-complement values. A high hit is sample >= high limit. A low hit is sample < low limit, so a sample equal to the low limit is not a low hit.
- R3: The fault-queue field fq_i selects the number of consecutive hits required: 2'b00 = 1, 2'b01 = 2, 2'b10 = 4, 2'b11 = 6. A valid sample that is not a hit restarts the count.
- R4: In interrupt mode (tm_i = 1), the block first watches the high limit. alert_flag_o sets in the cycle after the valid sample that completes the required run of high hits.
- R5: In interrupt mode, a latched alert stays set until a rd_clr_i pulse, an ara_clr_i pulse or shutdown_i clears it. Samples that arrive while it is latched do not change it.
- R6: In interrupt mode, a clear by rd_clr_i or ara_clr_i moves the watch to the low limit, where high hits are ignored and a run of low hits sets the alert. Clearing that alert moves the watch back to the high limit.
- R7: A change of tm_i, or shutdown_i high, resets the history: alert cleared, watch set back to the high limit, count zero. While shutdown_i is high, samples are ignored.
- R8: In comparator mode (tm_i = 0), the alert sets after the fault-queue count of high hits and clears after the fault-queue count of low hits. rd_clr_i and ara_clr_i have no effect.
- R9: alert_o is alert_flag_o XOR pol_i. pol_i never changes alert_flag_o, and with no sample, clear, shutdown or mode change the flag holds.
- R10: In interrupt mode, if a clear pulse and a valid sample arrive in the same cycle while the alert is latched, the clear takes effect and that sample is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_valid_i | input | 1 | One-cycle strobe marking a completed conversion |
| sample_i | input | 12 | Signed temperature sample |
| high_lim_i | input | 12 | Signed high limit |
| low_lim_i | input | 12 | Signed low limit |
| tm_i | input | 1 | Thermostat mode: 0 comparator, 1 interrupt |
| fq_i | input | 2 | Fault-queue field |
| pol_i | input | 1 | 1 inverts alert_o |
| shutdown_i | input | 1 | Shutdown command, level |
| rd_clr_i | input | 1 | Register-read pulse |
| ara_clr_i | input | 1 | Successful alert-response pulse |
| alert_o | output | 1 | Physical alert pin after polarity |
| alert_flag_o | output | 1 | Internal alert state, active high |

## Verification
The collision of interest is a clear event and a conversion result arriving in the same cycle while an interrupt-mode alert is latched. The bench provokes it by raising rd_clr_i and sample_valid_i in one cycle, with a sample that would be a low hit at a fault-queue depth of one. It then judges the outcome from alert_flag_o: the flag must read 0 afterwards. If the sample had been counted on the newly armed low side, the flag would read 1. A second such collision is a tm_i change or shutdown coinciding with a latched alert; that case is judged by the watch having returned to the high limit.

// File: rtl/tal_pkg.sv
package tal_pkg;
  localparam int FQ_W  = 2;
  localparam int CNT_W = 3;

  // consecutive-hit count selected by the fault-queue field
  function automatic logic [CNT_W-1:0] fq_need(input logic [FQ_W-1:0] fq);
    case (fq)
      2'b00:   return CNT_W'(1);
      2'b01:   return CNT_W'(2);
      2'b10:   return CNT_W'(4);
      default: return CNT_W'(6);
    endcase
  endfunction
endpackage

// File: rtl/tal_cmp.sv
module tal_cmp #(
  parameter int W = 12
) (
  input  logic signed [W-1:0] sample_i,
  input  logic signed [W-1:0] high_lim_i,
  input  logic signed [W-1:0] low_lim_i,
  output logic                ge_high_o,
  output logic                lt_low_o
);
  always_comb begin
    ge_high_o = (sample_i >= high_lim_i);
    lt_low_o  = (sample_i <  low_lim_i);
  end
endmodule

// File: rtl/tal_qual.sv
module tal_qual #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             step_i,
  input  logic             hit_i,
  input  logic [CNT_W-1:0] need_i,
  output logic             fire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;

  assign cnt_inc = cnt_q + 1'b1;
  // >= keeps a shrinking fq_i from overrunning the count
  assign fire_o  = step_i & hit_i & (cnt_inc >= need_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (flush_i)                   cnt_q <= '0;
    else if (step_i) begin
      if (!hit_i || fire_o)             cnt_q <= '0;
      else                              cnt_q <= cnt_inc;
    end
  end
endmodule

// File: rtl/tal_hist.sv
module tal_hist (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tm_i,
  input  logic shutdown_i,
  output logic hist_clr_o
);
  logic tm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tm_q <= 1'b0;
    else         tm_q <= tm_i;
  end

  assign hist_clr_o = shutdown_i | (tm_q != tm_i);
endmodule

// File: rtl/temp_alert_ctrl.sv
module temp_alert_ctrl #(
  parameter int TEMP_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_valid_i,
  input  logic [TEMP_W-1:0] sample_i,
  input  logic [TEMP_W-1:0] high_lim_i,
  input  logic [TEMP_W-1:0] low_lim_i,
  input  logic              tm_i,
  input  logic [1:0]        fq_i,
  input  logic              pol_i,
  input  logic              shutdown_i,
  input  logic              rd_clr_i,
  input  logic              ara_clr_i,
  output logic              alert_o,
  output logic              alert_flag_o
);
  import tal_pkg::*;

  logic             ge_high, lt_low;
  logic             hist_clr, clr_evt, step, hit, side, fire;
  logic             alert_q, watch_low_q;
  logic [CNT_W-1:0] need;

  tal_cmp #(.W(TEMP_W)) u_cmp (
    .sample_i   (sample_i),
    .high_lim_i (high_lim_i),
    .low_lim_i  (low_lim_i),
    .ge_high_o  (ge_high),
    .lt_low_o   (lt_low)
  );

  tal_hist u_hist (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tm_i       (tm_i),
    .shutdown_i (shutdown_i),
    .hist_clr_o (hist_clr)
  );

  assign need    = fq_need(fq_i);
  // comparator mode watches the side opposite to the current state
  assign side    = tm_i ? watch_low_q : alert_q;
  assign hit     = side ? lt_low : ge_high;
  assign clr_evt = tm_i & alert_q & (rd_clr_i | ara_clr_i);
  assign step    = sample_valid_i & ~hist_clr & ~clr_evt & ~(tm_i & alert_q);

  tal_qual #(.CNT_W(CNT_W)) u_qual (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (hist_clr | clr_evt),
    .step_i  (step),
    .hit_i   (hit),
    .need_i  (need),
    .fire_o  (fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alert_q     <= 1'b0;
      watch_low_q <= 1'b0;
    end else if (hist_clr) begin
      alert_q     <= 1'b0;
      watch_low_q <= 1'b0;
    end else if (clr_evt) begin
      alert_q     <= 1'b0;
      watch_low_q <= ~watch_low_q;
    end else if (fire) begin
      alert_q     <= tm_i ? 1'b1 : ~alert_q;
    end
  end

  assign alert_flag_o = alert_q;
  assign alert_o      = alert_q ^ pol_i;
endmodule

// File: rtl/tal_chk.sv
module tal_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sample_valid_i,
  input logic tm_i,
  input logic shutdown_i,
  input logic rd_clr_i,
  input logic ara_clr_i,
  input logic alert_flag_o
);
  logic tm_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tm_d <= 1'b0;
    else         tm_d <= tm_i;
  end

  // R7
  shutdown_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_i |=> !alert_flag_o);

  // R5
  int_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tm_i && alert_flag_o && (rd_clr_i || ara_clr_i)) |=> !alert_flag_o);

  // R5
  int_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(alert_flag_o) && $past(tm_i && (tm_i == tm_d)))
      |-> $past(rd_clr_i || ara_clr_i || shutdown_i));

  // R4
  rise_on_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alert_flag_o) |-> $past(sample_valid_i && !shutdown_i));

  // R9
  flag_steady_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sample_valid_i && !rd_clr_i && !ara_clr_i && !shutdown_i && (tm_i == tm_d))
      |=> $stable(alert_flag_o));
endmodule

bind temp_alert_ctrl tal_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .sample_valid_i (sample_valid_i),
  .tm_i           (tm_i),
  .shutdown_i     (shutdown_i),
  .rd_clr_i       (rd_clr_i),
  .ara_clr_i      (ara_clr_i),
  .alert_flag_o   (alert_flag_o)
);

// File: tb/temp_alert_ctrl_test.sv
module temp_alert_ctrl_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sample_valid_i = 1'b0;
  logic [11:0] sample_i = '0;
  logic [11:0] high_lim_i = 12'd80;
  logic [11:0] low_lim_i = 12'd75;
  logic        tm_i = 1'b0;
  logic [1:0]  fq_i = 2'b00;
  logic        pol_i = 1'b0;
  logic        shutdown_i = 1'b0;
  logic        rd_clr_i = 1'b0;
  logic        ara_clr_i = 1'b0;
  logic        alert_o, alert_flag_o;

  int errors = 0;
  int checks = 0;

  always #2 clk_i = ~clk_i;

  temp_alert_ctrl uut (.*);

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic smp(input int t);
    @(negedge clk_i);
    sample_i = 12'(t);
    sample_valid_i = 1'b1;
    @(negedge clk_i);
    sample_valid_i = 1'b0;
  endtask

  task automatic pulse_rd;
    @(negedge clk_i); rd_clr_i = 1'b1;
    @(negedge clk_i); rd_clr_i = 1'b0;
  endtask

  task automatic pulse_ara;
    @(negedge clk_i); ara_clr_i = 1'b1;
    @(negedge clk_i); ara_clr_i = 1'b0;
  endtask

  task automatic setup(input logic tm, input logic [1:0] fq, input int hi, input int lo);
    @(negedge clk_i);
    tm_i = tm; fq_i = fq; high_lim_i = 12'(hi); low_lim_i = 12'(lo);
    shutdown_i = 1'b1;
    @(negedge clk_i);
    shutdown_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 flag after reset", alert_flag_o, 1'b0);
    chk("R1 pin after reset", alert_o, 1'b0);
    pol_i = 1'b1; #1;
    chk("R1 pin follows pol", alert_o, 1'b1);
    pol_i = 1'b0; #1;
  endtask

  task automatic t_int_high;
    setup(1'b1, 2'b01, 80, 75);
    smp(85); chk("R3 one of two hits", alert_flag_o, 1'b0);
    smp(70); chk("R3 miss restarts", alert_flag_o, 1'b0);
    smp(85); chk("R3 run restarted", alert_flag_o, 1'b0);
    smp(85); chk("R4 high run sets", alert_flag_o, 1'b1);
  endtask

  task automatic t_int_latch_low;
    for (int i = 0; i < 4; i++) smp(70);
    chk("R5 latched through samples", alert_flag_o, 1'b1);
    pulse_rd; chk("R5 read clears", alert_flag_o, 1'b0);
    smp(90); smp(90); chk("R6 high ignored on low watch", alert_flag_o, 1'b0);
    smp(70); chk("R6 one low hit", alert_flag_o, 1'b0);
    smp(70); chk("R6 low run sets", alert_flag_o, 1'b1);
    pulse_ara; chk("R5 alert response clears", alert_flag_o, 1'b0);
    smp(70); smp(70); smp(70); chk("R6 back on high watch", alert_flag_o, 1'b0);
    smp(85); smp(85); chk("R6 high run sets again", alert_flag_o, 1'b1);
  endtask

  task automatic t_signed;
    setup(1'b1, 2'b00, -5, -20);
    smp(-6); chk("R2 -6 below -5", alert_flag_o, 1'b0);
    smp(5); chk("R2 +5 at or above -5", alert_flag_o, 1'b1);
    pulse_rd;
    smp(-20); chk("R2 equal low not a hit", alert_flag_o, 1'b0);
    smp(-21); chk("R2 -21 below -20", alert_flag_o, 1'b1);
    pulse_rd;
    smp(-5); chk("R2 equal high is a hit", alert_flag_o, 1'b1);
  endtask

  task automatic t_fq;
    setup(1'b1, 2'b11, 80, 75);
    for (int i = 0; i < 5; i++) smp(85);
    chk("R3 five of six", alert_flag_o, 1'b0);
    smp(85); chk("R3 six sets", alert_flag_o, 1'b1);
    setup(1'b1, 2'b10, 80, 75);
    for (int i = 0; i < 3; i++) smp(85);
    smp(79);
    for (int i = 0; i < 3; i++) smp(85);
    chk("R3 three after miss", alert_flag_o, 1'b0);
    smp(85); chk("R3 four sets", alert_flag_o, 1'b1);
  endtask

  task automatic t_history;
    setup(1'b1, 2'b00, 80, 75);
    smp(85); pulse_rd;
    @(negedge clk_i); tm_i = 1'b0;
    @(negedge clk_i); tm_i = 1'b1;
    @(negedge clk_i);
    smp(70); chk("R7 mode change rearms high", alert_flag_o, 1'b0);
    smp(85); chk("R7 high watch after change", alert_flag_o, 1'b1);
    @(negedge clk_i); shutdown_i = 1'b1;
    @(negedge clk_i);
    chk("R7 shutdown clears", alert_flag_o, 1'b0);
    smp(85); chk("R7 sample ignored in shutdown", alert_flag_o, 1'b0);
    shutdown_i = 1'b0;
  endtask

  task automatic t_comp;
    setup(1'b0, 2'b01, 80, 75);
    smp(85); chk("R8 one high hit", alert_flag_o, 1'b0);
    smp(85); chk("R8 sets", alert_flag_o, 1'b1);
    pulse_rd; chk("R8 read ignored", alert_flag_o, 1'b1);
    pulse_ara; chk("R8 response ignored", alert_flag_o, 1'b1);
    smp(78); smp(70); chk("R8 one low hit", alert_flag_o, 1'b1);
    smp(70); chk("R8 low run clears", alert_flag_o, 1'b0);
    smp(85); chk("R8 needs full run again", alert_flag_o, 1'b0);
  endtask

  task automatic t_pol;
    setup(1'b1, 2'b00, 80, 75);
    smp(85);
    chk("R9 pin active high", alert_o, 1'b1);
    @(negedge clk_i); pol_i = 1'b1;
    @(negedge clk_i);
    chk("R9 pin inverted", alert_o, 1'b0);
    chk("R9 flag unaffected", alert_flag_o, 1'b1);
    @(negedge clk_i); pol_i = 1'b0;
    @(negedge clk_i);
    chk("R9 flag still set", alert_flag_o, 1'b1);
  endtask

  task automatic t_collide;
    setup(1'b1, 2'b00, 80, 75);
    smp(85);
    @(negedge clk_i);
    rd_clr_i = 1'b1; sample_i = 12'd70; sample_valid_i = 1'b1;
    @(negedge clk_i);
    rd_clr_i = 1'b0; sample_valid_i = 1'b0;
    chk("R10 clear wins, sample dropped", alert_flag_o, 1'b0);
    smp(70); chk("R10 next low sample counts", alert_flag_o, 1'b1);
  endtask

  initial begin
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset;
    t_int_high;
    t_int_latch_low;
    t_signed;
    t_fq;
    t_history;
    t_comp;
    t_pol;
    t_collide;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule